// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Indicator

This block compares two divided pulse streams, the reference stream and the feedback stream, and tells a downstream charge pump which way to steer the oscillator. It is a three-state, edge-triggered comparator. Both inputs pass through a synchronizer and are edge-detected on a fast sampling clock. A rising edge on one input opens a correction pulse, and the matching edge on the other input closes it. When no correction is in progress, the lock indicator shows that the two streams are in phase. All three outputs are registered and active-low, as if each one drove an open-drain pin.

The controller has three states. `PH_IDLE` means no correction is pending. `PH_UP` means the reference edge came first and the comparator is waiting for the feedback edge. `PH_DN` means the feedback edge came first and the comparator is waiting for the reference edge. The transitions are these:
- *open-up*: `PH_IDLE` to `PH_UP` on a reference edge alone.
- *open-down*: `PH_IDLE` to `PH_DN` on a feedback edge alone.
- *close-up*: `PH_UP` to `PH_IDLE` on a feedback edge alone.
- *close-down*: `PH_DN` to `PH_IDLE` on a reference edge alone.
- *coincide*: `PH_IDLE` stays in `PH_IDLE` when both edges arrive in the same sample.
- *slip*: a second leading edge while a pulse is open leaves the state unchanged. The correction therefore saturates at a full cycle, and the extra cycle is absorbed.
- *renew*: both edges arrive while a pulse is open. The closing edge ends the old pulse and the leading edge starts a new one, so the state is kept.

Within one input period the correction pulse width equals the edge separation in sampling cycles. This gives a linear response over one full cycle of phase error in either direction.

Top module: `pfd_lock_cmp`

## Requirements
- R1: While `rst_n` is low, and right after it rises with both inputs low, `up_n`=1, `dn_n`=1 and `lock_n`=0.
- R2: From the idle state, a rising edge on `ref_in` alone drives `up_n` low. A later rising edge on `fb_in` alone returns it high. The low time equals the edge separation in sampling cycles.
- R3: From the idle state, a rising edge on `fb_in` alone drives `dn_n` low. A later rising edge on `ref_in` alone returns it high. The low time equals the edge separation.
- R4: Rising edges on both inputs in the same sample while idle produce no pulse on `up_n` or `dn_n`.
- R5: `lock_n` is 0 exactly when both `up_n` and `dn_n` are 1, and is 1 otherwise.
- R6: `up_n` and `dn_n` are never low together.
- R7: While `up_n` is low, only a feedback edge can end the pulse, and further reference edges keep it low. The same holds for `dn_n` with the roles of the inputs swapped.
- R8: With both edges in one sample while a pulse is open, the pulse stays low without a gap, because the closing edge ends the old pulse and the leading edge starts a new one.
- R9: A rising input edge changes the outputs exactly `SYNC_STAGES`+1 sampling edges after the input is first sampled high. If no edge is detected, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Divided reference pulse stream |
| fb_in | input | 1 | Divided feedback (oscillator) pulse stream |
| up_n | output | 1 | Active-low raise-frequency pulse |
| dn_n | output | 1 | Active-low lower-frequency pulse |
| lock_n | output | 1 | Active-low in-phase indicator |

## Verification
An input driven high before sampling edge k first affects the outputs after edge k+`SYNC_STAGES`. With the default of two stages, that is the third edge. The bench therefore compares the expected result of table row r when row r+`SYNC_STAGES`+1 is applied, and it samples at the falling clock edge that follows the update. The directed width tests count low cycles over a window wide enough to cover the latency, so pulse widths are compared without depending on when a pulse starts. The latency test checks the outputs both one sampling edge before the due edge and at the due edge.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_UP   = 2'b01,
        PH_DN   = 2'b10
    } pfd_state_t;

    localparam int unsigned CH_REF = 0;
    localparam int unsigned CH_FB  = 1;
    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/pfd_edge_sense.sv
module pfd_edge_sense #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic up_n,
    output logic dn_n,
    output logic lock_n
);
    pfd_state_t state_q;
    pfd_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (ref_rise && !fb_rise)      state_d = PH_UP;   // open-up
                else if (fb_rise && !ref_rise) state_d = PH_DN;   // open-down
                else                           state_d = PH_IDLE; // coincide / quiet
            end
            PH_UP: begin
                if (fb_rise && !ref_rise) state_d = PH_IDLE;      // close-up
                else                      state_d = PH_UP;        // slip / renew
            end
            PH_DN: begin
                if (ref_rise && !fb_rise) state_d = PH_IDLE;      // close-down
                else                      state_d = PH_DN;        // slip / renew
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_n   <= 1'b1;
            dn_n   <= 1'b1;
            lock_n <= 1'b0;
        end else begin
            up_n   <= (state_d != PH_UP);
            dn_n   <= (state_d != PH_DN);
            lock_n <= (state_d != PH_IDLE);
        end
    end

endmodule

// File: rtl/pfd_lock_cmp.sv
module pfd_lock_cmp
    import pfd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    output logic up_n,
    output logic dn_n,
    output logic lock_n
);
    logic [NUM_CH-1:0] pin_vec;
    logic [NUM_CH-1:0] rise_vec;
    logic              ref_rise;
    logic              fb_rise;

    assign pin_vec[CH_REF] = ref_in;
    assign pin_vec[CH_FB]  = fb_in;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sense
            pfd_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (pin_vec[ch]),
                .rise (rise_vec[ch])
            );
        end
    endgenerate

    assign ref_rise = rise_vec[CH_REF];
    assign fb_rise  = rise_vec[CH_FB];

    pfd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_rise(ref_rise),
        .fb_rise (fb_rise),
        .up_n    (up_n),
        .dn_n    (dn_n),
        .lock_n  (lock_n)
    );

endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_rise,
    input logic fb_rise,
    input logic up_n,
    input logic dn_n,
    input logic lock_n
);
    p_reset_outputs_r1: assert property (@(posedge clk)
        !rst_n |=> (up_n && dn_n && !lock_n));

    p_open_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n && dn_n && ref_rise && !fb_rise) |=> !up_n);

    p_close_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && fb_rise && !ref_rise) |=> (up_n && dn_n));

    p_open_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n && dn_n && fb_rise && !ref_rise) |=> !dn_n);

    p_close_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_n && ref_rise && !fb_rise) |=> (up_n && dn_n));

    p_coincide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n && dn_n && ref_rise && fb_rise) |=> (up_n && dn_n));

    p_lock_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_n == !(up_n && dn_n));

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~up_n, ~dn_n}) <= 1);

    p_slip_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && !fb_rise) |=> !up_n);

    p_slip_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_n && !ref_rise) |=> !dn_n);

    p_renew_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(up_n && dn_n) && ref_rise && fb_rise) |=> $stable({up_n, dn_n}));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_rise && !fb_rise) |=> $stable({up_n, dn_n, lock_n}));

endmodule

bind pfd_lock_cmp pfd_lock_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(ref_rise),
    .fb_rise (fb_rise),
    .up_n    (up_n),
    .dn_n    (dn_n),
    .lock_n  (lock_n)
);

// File: tb/pfd_lock_cmp_bench.sv
`timescale 1ns/1ps
module pfd_lock_cmp_bench;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int LAT = SYNC_STAGES + 1;
    localparam int NROW = 31;

    // {ref, fb, up_n, dn_n, lock_n}; output bits = state after this row
    localparam logic [4:0] VEC [0:NROW-1] = '{
        5'b00_110, 5'b10_011, 5'b00_011, 5'b01_110, 5'b00_110,
        5'b01_101, 5'b00_101, 5'b10_110, 5'b00_110, 5'b11_110,
        5'b00_110, 5'b10_011, 5'b00_011, 5'b10_011, 5'b00_011,
        5'b01_110, 5'b00_110, 5'b01_101, 5'b00_101, 5'b11_101,
        5'b00_101, 5'b10_110, 5'b00_110, 5'b10_011, 5'b00_011,
        5'b11_011, 5'b00_011, 5'b01_110, 5'b00_110, 5'b00_110,
        5'b00_110
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic up_n, dn_n, lock_n;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pfd_lock_cmp #(.SYNC_STAGES(SYNC_STAGES)) u_pfd_lock_cmp (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .up_n(up_n), .dn_n(dn_n), .lock_n(lock_n)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ref_in = 1'b0;
            fb_in  = 1'b0;
        end
    endtask

    // lead_ref=1: ref first (UP); else fb first (DN). returns low count on that output
    task automatic width_run(input bit lead_ref, input int gap, output int low_cnt);
        low_cnt = 0;
        for (int k = 0; k < gap + LAT + 6; k++) begin
            @(negedge clk);
            if (lead_ref ? !up_n : !dn_n) low_cnt++;
            ref_in = lead_ref ? (k == 0) : (k == gap);
            fb_in  = lead_ref ? (k == gap) : (k == 0);
        end
    endtask

    initial begin
        int w;
        logic [4:0] row;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1 up_n in reset", up_n, 1);
        check("R1 dn_n in reset", dn_n, 1);
        check("R1 lock_n in reset", lock_n, 0);
        rst_n = 1'b1;
        idle_cycles(4);
        check("R1 lock_n after reset", lock_n, 0);
        check("R1 up_n after reset", up_n, 1);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NROW + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT) begin
                row = VEC[i - LAT];
                check($sformatf("R2/R3/R4/R7/R8 row %0d up_n", i - LAT), up_n, row[2]);
                check($sformatf("R2/R3/R4/R7/R8 row %0d dn_n", i - LAT), dn_n, row[1]);
                check($sformatf("R5 row %0d lock_n", i - LAT), lock_n, row[0]);
                check($sformatf("R6 row %0d exclusive", i - LAT), int'(!up_n && !dn_n), 0);
            end
            if (i < NROW) begin
                row = VEC[i];
                ref_in = row[4];
                fb_in  = row[3];
            end else begin
                ref_in = 1'b0;
                fb_in  = 1'b0;
            end
        end

        // R2 / R3 pulse width equals edge separation
        width_run(1'b1, 6, w);
        check("R2 up_n low width", w, 6);
        width_run(1'b0, 4, w);
        check("R3 dn_n low width", w, 4);
        width_run(1'b1, 1, w);
        check("R2 up_n minimum width", w, 1);

        // R9 latency
        @(negedge clk);
        ref_in = 1'b1;
        for (int k = 1; k <= LAT; k++) begin
            @(negedge clk);
            ref_in = 1'b0;
            if (k == LAT - 1) check("R9 up_n before due edge", up_n, 1);
            if (k == LAT)     check("R9 up_n at due edge", up_n, 0);
        end
        // R9 held-high reference level adds no edge
        ref_in = 1'b1;
        for (int k = 0; k < 8; k++) @(negedge clk);
        fb_in = 1'b1;
        idle_cycles(LAT + 3);
        check("R9 held level then fb closes up_n", up_n, 1);
        check("R9 lock_n after close", lock_n, 0);

        // R1: reset during an open pulse
        @(negedge clk);
        fb_in = 1'b1;
        idle_cycles(LAT + 1);
        check("R3 dn_n open before reset", dn_n, 0);
        rst_n = 1'b0;
        #1;
        check("R1 dn_n on async reset", dn_n, 1);
        check("R1 lock_n on async reset", lock_n, 0);
        idle_cycles(2);
        rst_n = 1'b1;
        idle_cycles(LAT + 2);
        check("R1 quiet after reset release", int'({up_n, dn_n, lock_n}), 3'b110);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule